// File: doc/BRIEF.md
# Six-Step Single-PWM Commutation Decoder

This block turns one PWM signal and a 3-bit rotor position code into the six gate commands of a three-phase half-bridge stage. The position code usually comes straight from the motor's hall sensors. It picks which phase is modulated and which phase has its low side held on. The PWM input alone sets the switching frequency and the duty cycle. A direction input reverses rotation, and an active-low brake input shorts the windings through the low sides. A mode input chooses how the modulated phase's low side behaves. In complementary mode it follows the inverse of the PWM. In freewheeling mode it stays off and the body diode carries the current.

All control inputs pass through synchronizers, and the decoded phase roles are registered. Each phase then has its own dead-time stage. That stage holds back every rising gate command until the phase has been fully off for a run-time programmable number of cycles. The outputs are registered, free of glitches, and never turn on both transistors of one half-bridge.

Top module: `sixstep_commutator`

## Requirements
- R1: Position code 000 (bit 2 = input A, bit 1 = B, bit 0 = C) is Stop. All six gate outputs are driven low.
- R2: Code 111 is Align. Phase A high side follows the PWM, and phases B and C have their low sides on. This holds in either direction.
- R3: With rev_dir = 0, codes map to (modulated phase, low-on phase) as follows: 110 → (B, C), 100 → (A, C), 101 → (A, B), 001 → (C, B), 011 → (C, A), 010 → (B, A). The third phase has both gates off.
- R4: With rev_dir = 1, the six commutation codes are bit-inverted before the lookup of R3. Codes 000 and 111 keep their meaning.
- R5: With freewheel_mode = 0, the modulated phase's low gate is the complement of the PWM. Its high gate equals the PWM.
- R6: With freewheel_mode = 1, the modulated phase's low gate stays low whatever the PWM level.
- R7: While brake_n is 0, all high gates are off and all low gates are on, whatever the PWM, code, direction and mode inputs are.
- R8: A gate of a phase rises only after both gates of that phase have been low for at least dead_cycles+1 clock cycles. When the complement is requested at the same moment the other gate is released, the gap is exactly dead_cycles+1.
- R9: The high and low gate of one phase are never high in the same cycle.
- R10: An input change reaches a gate output on the 4th rising clock edge after the input is sampled. This applies to every turn-off, and to every turn-on from a phase that has been off long enough.
- R11: While rst is high, and afterwards until decoded inputs arrive, all gates are low. The brake synchronizer resets to the not-braking state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM that sets frequency and duty of the modulated phase |
| pos_code | input | 3 | Position code {A,B,C}, usually hall sensor outputs |
| rev_dir | input | 1 | 1 reverses rotation by inverting the commutation codes |
| brake_n | input | 1 | Active-low brake: all low sides on, all high sides off |
| freewheel_mode | input | 1 | 0 complementary low side, 1 diode freewheeling |
| dead_cycles | input | DEAD_W | Dead time in clock cycles (gap is this value + 1) |
| gate_hi | output | 3 | High-side gate commands, bit 0 = phase A |
| gate_lo | output | 3 | Low-side gate commands, bit 0 = phase A |

## Verification
A corrupt registered role or a wrong table entry shows up four clocks after the input change. It appears as a gate that is on when it should be off, or one that never rises. The settled-state sweep compares every code, direction, mode, brake and PWM level against an independent table. A dead-time counter that misses a reset or saturates early shows up at the next PWM edge. The gap is then shorter or longer than dead_cycles+1, or both gates overlap. A monitor measures every off gap and every overlap on every phase throughout the run.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;
  localparam int NPH = 3;
  localparam int SYNC_W = 7;

  // Which phases are modulated and which hold their low side on
  typedef struct packed {
    logic [NPH-1:0] pwm_sel;
    logic [NPH-1:0] low_sel;
  } drive_t;

  // Reverse direction: invert the six commutation codes, keep 000/111
  function automatic logic [2:0] fold_code(input logic [2:0] c, input logic rev);
    if (rev && (c != 3'b000) && (c != 3'b111)) return ~c;
    return c;
  endfunction

  // Phase index: 0 = A, 1 = B, 2 = C. Code bit 2 = A, bit 1 = B, bit 0 = C.
  function automatic drive_t code_to_drive(input logic [2:0] c);
    drive_t d;
    d = '0;
    case (c)
      3'b111: begin d.pwm_sel = 3'b001; d.low_sel = 3'b110; end
      3'b110: begin d.pwm_sel = 3'b010; d.low_sel = 3'b100; end
      3'b100: begin d.pwm_sel = 3'b001; d.low_sel = 3'b100; end
      3'b101: begin d.pwm_sel = 3'b001; d.low_sel = 3'b010; end
      3'b001: begin d.pwm_sel = 3'b100; d.low_sel = 3'b010; end
      3'b011: begin d.pwm_sel = 3'b100; d.low_sel = 3'b001; end
      3'b010: begin d.pwm_sel = 3'b010; d.low_sel = 3'b001; end
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) chain[i] <= chain[i-1];
      chain[0] <= d;
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ss_decode.sv
module ss_decode
  import sixstep_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     code,
  input  logic           rev,
  input  logic           brake_n,
  input  logic           pwm,
  input  logic           freewheel,
  output logic [NPH-1:0] req_hi,
  output logic [NPH-1:0] req_lo
);
  drive_t drv_q;
  logic   pwm_q;
  logic   brake_q;
  logic   fw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q   <= '0;
      pwm_q   <= 1'b0;
      brake_q <= 1'b0;
      fw_q    <= 1'b0;
    end else begin
      drv_q   <= code_to_drive(fold_code(code, rev));
      pwm_q   <= pwm;
      brake_q <= ~brake_n;
      fw_q    <= freewheel;
    end
  end

  always_comb begin
    for (int p = 0; p < NPH; p++) begin
      req_hi[p] = !brake_q && drv_q.pwm_sel[p] && pwm_q;
      req_lo[p] = brake_q || drv_q.low_sel[p] ||
                  (drv_q.pwm_sel[p] && !fw_q && !pwm_q);
    end
  end
endmodule

// File: rtl/ss_deadtime.sv
module ss_deadtime #(
  parameter int DEAD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEAD_W-1:0] dead,
  input  logic              req_hi,
  input  logic              req_lo,
  output logic              hi,
  output logic              lo
);
  localparam logic [DEAD_W-1:0] CNT_MAX = '1;

  logic [DEAD_W-1:0] off_cnt;
  logic              gap_ok;

  assign gap_ok = (off_cnt >= dead);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi      <= 1'b0;
      lo      <= 1'b0;
      off_cnt <= '0;
    end else begin
      hi <= req_hi && !req_lo && (hi || (!lo && gap_ok));
      lo <= req_lo && !req_hi && (lo || (!hi && gap_ok));
      if (hi || lo)                off_cnt <= '0;
      else if (off_cnt != CNT_MAX) off_cnt <= off_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sixstep_commutator.sv
module sixstep_commutator
  import sixstep_pkg::*;
#(
  parameter int DEAD_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwm_in,
  input  logic [2:0]        pos_code,
  input  logic              rev_dir,
  input  logic              brake_n,
  input  logic              freewheel_mode,
  input  logic [DEAD_W-1:0] dead_cycles,
  output logic [NPH-1:0]    gate_hi,
  output logic [NPH-1:0]    gate_lo
);
  // Vector order: {pwm, code[2:0], rev, brake_n, freewheel}; brake_n resets to 1
  localparam logic [SYNC_W-1:0] SYNC_RST = 7'b0_000_0_1_0;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] syn;
  logic [NPH-1:0]    req_hi;
  logic [NPH-1:0]    req_lo;

  assign raw_in = {pwm_in, pos_code, rev_dir, brake_n, freewheel_mode};

  ss_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn)
  );

  ss_decode u_dec (
    .clk(clk), .rst(rst),
    .code(syn[5:3]), .rev(syn[2]), .brake_n(syn[1]),
    .pwm(syn[6]), .freewheel(syn[0]),
    .req_hi(req_hi), .req_lo(req_lo)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    ss_deadtime #(.DEAD_W(DEAD_W)) u_dt (
      .clk(clk), .rst(rst), .dead(dead_cycles),
      .req_hi(req_hi[p]), .req_lo(req_lo[p]),
      .hi(gate_hi[p]), .lo(gate_lo[p])
    );
  end
endmodule

// File: rtl/sixstep_commutator_chk.sv
module sixstep_commutator_chk #(
  parameter int DEAD_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              brake_n,
  input logic [2:0]        pos_code,
  input logic [DEAD_W-1:0] dead_cycles,
  input logic [2:0]        gate_hi,
  input logic [2:0]        gate_lo
);
  logic rst_seen = 1'b0;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen) begin
      p_reset_low_r11: assert (gate_hi == 3'b000 && gate_lo == 3'b000)
        else $error("R11 gates active right after reset");
    end
  end

  p_brake_hi_off_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(brake_n, 4) |-> gate_hi == 3'b000);

  p_stop_all_off_r1: assert property (@(posedge clk) disable iff (rst)
    $past(brake_n && pos_code == 3'b000, 4) |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

  for (genvar p = 0; p < 3; p++) begin : g_ph
    logic [DEAD_W:0] off_run;
    always_ff @(posedge clk) begin
      if (rst) off_run <= '0;
      else if (gate_hi[p] || gate_lo[p]) off_run <= '0;
      else if (off_run != '1) off_run <= off_run + 1'b1;
    end

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
      !(gate_hi[p] && gate_lo[p]));

    p_dead_gap_hi_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_hi[p]) |-> off_run > {1'b0, dead_cycles});

    p_dead_gap_lo_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_lo[p]) |-> off_run > {1'b0, dead_cycles});
  end
endmodule

bind sixstep_commutator sixstep_commutator_chk #(.DEAD_W(DEAD_W)) u_chk (
  .clk(clk), .rst(rst), .brake_n(brake_n), .pos_code(pos_code),
  .dead_cycles(dead_cycles), .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/sixstep_commutator_test.sv
module sixstep_commutator_test;
  localparam int DEAD_W = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pwm_in = 1'b0;
  logic [2:0]        pos_code = 3'b000;
  logic              rev_dir = 1'b0;
  logic              brake_n = 1'b1;
  logic              freewheel_mode = 1'b0;
  logic [DEAD_W-1:0] dead_cycles = 6'd3;
  logic [2:0]        gate_hi;
  logic [2:0]        gate_lo;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sixstep_commutator #(.DEAD_W(DEAD_W)) uut (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .pos_code(pos_code),
    .rev_dir(rev_dir), .brake_n(brake_n), .freewheel_mode(freewheel_mode),
    .dead_cycles(dead_cycles), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // Gap and overlap monitor, sampled on the falling edge
  int run [3] = '{0, 0, 0};
  int last_gap [3] = '{-1, -1, -1};
  logic [2:0] prev_on = 3'b000;
  int overlaps = 0;
  int gap_viol = 0;

  always @(negedge clk) begin
    for (int p = 0; p < 3; p++) begin
      if (gate_hi[p] && gate_lo[p]) overlaps++;
      if (!gate_hi[p] && !gate_lo[p]) begin
        run[p]++;
      end else begin
        if (!prev_on[p]) begin
          last_gap[p] = run[p];
          if (run[p] < int'(dead_cycles) + 1) gap_viol++;
        end
        run[p] = 0;
      end
      prev_on[p] = gate_hi[p] | gate_lo[p];
    end
  end

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual hi/lo=%b expected hi/lo=%b", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Settled outputs computed from the requirement table
  function automatic logic [5:0] model(input logic [2:0] c, input logic rev,
                                       input logic fw, input logic pwm, input logic bn);
    logic [2:0] e;
    logic [2:0] hi, lo, pm;
    if (!bn) return {3'b000, 3'b111};
    e = c;
    if (rev && c != 3'b000 && c != 3'b111) e = ~c;
    pm = 3'b000; lo = 3'b000;
    case (e)
      3'b111: begin pm = 3'b001; lo = 3'b110; end
      3'b110: begin pm = 3'b010; lo = 3'b100; end
      3'b100: begin pm = 3'b001; lo = 3'b100; end
      3'b101: begin pm = 3'b001; lo = 3'b010; end
      3'b001: begin pm = 3'b100; lo = 3'b010; end
      3'b011: begin pm = 3'b100; lo = 3'b001; end
      3'b010: begin pm = 3'b010; lo = 3'b001; end
      default: ;
    endcase
    hi = pwm ? pm : 3'b000;
    if (!pwm && !fw) lo = lo | pm;
    return {hi, lo};
  endfunction

  task automatic settle();
    repeat (int'(dead_cycles) + 12) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 during reset", {gate_hi, gate_lo}, 6'b0);
    brake_n = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    brake_n = 1'b1;
    @(negedge clk);
    check("R11 first cycle after reset", {gate_hi, gate_lo}, 6'b0);
    repeat (2) @(negedge clk);
    check("R11 before inputs decoded", {gate_hi, gate_lo}, 6'b0);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 2; m++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 8; c++)
          for (int w = 0; w < 2; w++) begin
            string tag;
            freewheel_mode = m[0]; rev_dir = d[0]; pos_code = c[2:0]; pwm_in = w[0];
            brake_n = 1'b1;
            settle();
            if (c == 0) tag = "R1 stop";
            else if (c == 7) tag = "R2 align";
            else if (d == 1) tag = "R4 reversed";
            else if (!w[0]) tag = m[0] ? "R6 freewheel" : "R5 complementary";
            else tag = "R3 forward";
            check(tag, {gate_hi, gate_lo}, model(c[2:0], d[0], m[0], w[0], 1'b1));
          end
  endtask

  task automatic t_brake();
    for (int c = 0; c < 8; c++) begin
      pos_code = c[2:0]; rev_dir = c[0]; pwm_in = c[1]; freewheel_mode = c[2];
      brake_n = 1'b0;
      settle();
      check("R7 brake override", {gate_hi, gate_lo}, 6'b000_111);
    end
    brake_n = 1'b1;
  endtask

  task automatic t_latency();
    freewheel_mode = 1'b0; rev_dir = 1'b0; pwm_in = 1'b1; pos_code = 3'b000;
    settle();
    pos_code = 3'b100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 before 4th edge", {gate_hi, gate_lo}, 6'b0);
    @(posedge clk);
    @(negedge clk);
    check("R10 at 4th edge", {gate_hi, gate_lo}, 6'b001_100);
  endtask

  task automatic t_deadgap(input int dv);
    dead_cycles = dv[DEAD_W-1:0];
    freewheel_mode = 1'b0; rev_dir = 1'b0; pos_code = 3'b100; pwm_in = 1'b1;
    settle();
    last_gap[0] = -1;
    pwm_in = 1'b0;
    settle();
    check_int("R8 gap before low side rises", last_gap[0], dv + 1);
    last_gap[0] = -1;
    pwm_in = 1'b1;
    settle();
    check_int("R8 gap before high side rises", last_gap[0], dv + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sweep();
    t_brake();
    t_latency();
    t_deadgap(3);
    t_deadgap(0);
    t_deadgap(7);
    check_int("R9 overlap cycles", overlaps, 0);
    check_int("R8 short gaps", gap_viol, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule